// File: doc/BRIEF.md
# Translation Lookaside Buffer with Invalidation

This block is a small fully associative translation cache. Each of its eight entries holds a 20-bit virtual page number, the 20-bit physical page number it maps to, and the user and writable permission bits of that mapping. A 4096-byte page size is assumed, so a virtual page number is the upper 20 bits of a 32-bit address.

A lookup is combinational. A virtual page number presented on the lookup port returns hit or miss, the physical page number and the cached permission bits in the same cycle, so a permission check on a hit needs no table walk.

After a walk, a fill installs the mapping. It goes into the lowest-numbered free entry, or else into a round-robin victim. A fill whose page is already cached overwrites that entry in place.

The cache does not watch memory. A mapping stays in the cache after the page tables that produced it change, until software removes it. There are two ways to do that:
- A write to the page-directory base register clears every entry.
- A single-page invalidate removes only the entry for one virtual page.

Top module: `tlb_cache`

## Requirements
- R1: After reset every entry is invalid, and every lookup misses.
- R2: A lookup is combinational. When a valid entry holds the presented virtual page number, `lookup_hit` is 1 in the same cycle, and `lookup_ppn`, `lookup_user` and `lookup_wr` carry that entry's stored values.
- R3: A fill installs the mapping at the next rising edge. From then on, lookups of that page hit with the filled physical page number and permission bits.
- R4: A fill of a page that is not present goes to the lowest-indexed invalid entry. When no entry is invalid, it replaces the entry named by a round-robin pointer. The pointer starts at entry 0 after reset and advances by one, wrapping, only on such a replacement.
- R5: A fill of a page that already hits overwrites that entry with the new translation. No other entry changes, and at most one valid entry ever holds a given page.
- R6: A pulse on `base_wr` invalidates every entry at the next edge.
- R7: A pulse on `inval_en` invalidates only the entry whose page equals `inval_vpn`. All other entries keep their mappings.
- R8: An invalidate of a page that is not cached changes nothing.
- R9: When a flush or invalidate coincides with a fill, the invalidation is applied first and the fill is still installed.
- R10: A lookup in the cycle of any update sees the state from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lookup_vpn | input | 20 | Virtual page number to translate |
| lookup_hit | output | 1 | A valid entry matches `lookup_vpn` |
| lookup_ppn | output | 20 | Physical page number of the matching entry |
| lookup_user | output | 1 | User-access bit of the matching entry |
| lookup_wr | output | 1 | Writable bit of the matching entry |
| fill_en | input | 1 | Install a translation this cycle |
| fill_vpn | input | 20 | Virtual page number being installed |
| fill_ppn | input | 20 | Physical page number being installed |
| fill_user | input | 1 | User-access bit being installed |
| fill_wr | input | 1 | Writable bit being installed |
| base_wr | input | 1 | Page-directory base register write; clears all entries |
| inval_en | input | 1 | Single-page invalidate request |
| inval_vpn | input | 20 | Page to invalidate, the upper 20 bits of the address |

## Verification
The assertions check three properties on every cycle:
- At most one entry matches a lookup, and no two valid entries ever share a page.
- A flush leaves at most the coinciding fill behind.
- An invalidated page misses and a filled page hits with its new translation on the following cycle.

Only the bench's scenarios can show the replacement order: which entry a fill lands in when the table is full or has a hole. The same holds for the ordering within a combined flush-and-fill cycle and for the old state seen by a same-cycle lookup.

// File: rtl/tlb_cache.sv
module tlb_cache #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lookup_vpn,
  output logic             lookup_hit,
  output logic [PPN_W-1:0] lookup_ppn,
  output logic             lookup_user,
  output logic             lookup_wr,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_user,
  input  logic             fill_wr,
  input  logic             base_wr,
  input  logic             inval_en,
  input  logic [VPN_W-1:0] inval_vpn
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid_q, user_q, wr_q;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q;

  logic [ENTRIES-1:0] look_m, inval_m, fill_m, kept, fill_sel;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign look_m[g]  = valid_q[g] && (tag_q[g] == lookup_vpn);
    assign inval_m[g] = valid_q[g] && (tag_q[g] == inval_vpn);
    assign fill_m[g]  = tag_q[g] == fill_vpn;
  end

  assign kept = valid_q & ~({ENTRIES{base_wr}}) & ~({ENTRIES{inval_en}} & inval_m);

  always_comb begin
    lookup_ppn  = '0;
    lookup_user = 1'b0;
    lookup_wr   = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (look_m[i]) begin
        lookup_ppn  = lookup_ppn | ppn_q[i];
        lookup_user = lookup_user | user_q[i];
        lookup_wr   = lookup_wr | wr_q[i];
      end
    end
  end
  assign lookup_hit = |look_m;

  logic             have_hit, have_free, use_rr;
  logic [IDX_W-1:0] hit_idx, free_idx, tgt;

  always_comb begin
    have_hit  = 1'b0;
    have_free = 1'b0;
    hit_idx   = '0;
    free_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (kept[i] && fill_m[i]) begin
        have_hit = 1'b1;
        hit_idx  = IDX_W'(i);
      end
      if (!kept[i]) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(i);
      end
    end
  end

  assign use_rr   = !have_hit && !have_free;
  assign tgt      = have_hit ? hit_idx : (have_free ? free_idx : rr_q);
  assign fill_sel = fill_en ? (ENTRIES'(1) << tgt) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else begin
      valid_q <= kept | fill_sel;
      if (fill_en && use_rr) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[tgt]  <= fill_vpn;
      ppn_q[tgt]  <= fill_ppn;
      user_q[tgt] <= fill_user;
      wr_q[tgt]   <= fill_wr;
    end
  end

  logic dup;
  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      for (int j = i + 1; j < ENTRIES; j++)
        if (valid_q[i] && valid_q[j] && tag_q[i] == tag_q[j]) dup = 1'b1;
  end

  p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_m));

  p_no_duplicate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dup);

  p_fill_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (lookup_vpn != $past(fill_vpn)) ||
                (lookup_hit && lookup_ppn == $past(fill_ppn)));

  p_flush_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |=> $countones(valid_q) <= 1);

  p_inval_gone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inval_en && !(fill_en && fill_vpn == inval_vpn)) |=>
      (lookup_vpn != $past(inval_vpn)) || !lookup_hit);
endmodule

// File: tb/tb_tlb_cache.sv
module tb_tlb_cache;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] lookup_vpn, fill_vpn, fill_ppn, inval_vpn;
  logic        lookup_hit, lookup_user, lookup_wr;
  logic [19:0] lookup_ppn;
  logic        fill_en, fill_user, fill_wr, base_wr, inval_en;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tlb_cache dut (
    .clk(clk), .rst_n(rst_n),
    .lookup_vpn(lookup_vpn), .lookup_hit(lookup_hit), .lookup_ppn(lookup_ppn),
    .lookup_user(lookup_user), .lookup_wr(lookup_wr),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_user(fill_user), .fill_wr(fill_wr),
    .base_wr(base_wr), .inval_en(inval_en), .inval_vpn(inval_vpn)
  );

  task automatic look(input logic [19:0] v, input bit eh, input logic [19:0] ep, input string req);
    lookup_vpn = v;
    #1;
    checks++;
    if (lookup_hit !== eh || (eh && lookup_ppn !== ep)) begin
      errors++;
      $display("FAIL %s vpn=%h got hit=%b ppn=%h expected hit=%b ppn=%h",
               req, v, lookup_hit, lookup_ppn, eh, ep);
    end
  endtask

  task automatic look_perm(input logic [19:0] v, input bit eu, input bit ew, input string req);
    lookup_vpn = v;
    #1;
    checks++;
    if (lookup_user !== eu || lookup_wr !== ew) begin
      errors++;
      $display("FAIL %s vpn=%h got user=%b wr=%b expected user=%b wr=%b",
               req, v, lookup_user, lookup_wr, eu, ew);
    end
  endtask

  task automatic fill(input logic [19:0] v, input logic [19:0] p, input bit u, input bit w);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = v; fill_ppn = p; fill_user = u; fill_wr = w;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk);
    base_wr = 1'b1;
    @(negedge clk);
    base_wr = 1'b0;
  endtask

  task automatic inval(input logic [19:0] v);
    @(negedge clk);
    inval_en = 1'b1; inval_vpn = v;
    @(negedge clk);
    inval_en = 1'b0;
  endtask

  task automatic t_reset();
    look(20'h00000, 1'b0, '0, "R1");
    look(20'h12345, 1'b0, '0, "R1");
  endtask

  task automatic t_basic();
    fill(20'h12345, 20'hABCDE, 1'b1, 1'b0);
    look(20'h12345, 1'b1, 20'hABCDE, "R3");
    look_perm(20'h12345, 1'b1, 1'b0, "R2");
    fill(20'h00042, 20'h00777, 1'b0, 1'b1);
    look(20'h00042, 1'b1, 20'h00777, "R2");
    look_perm(20'h00042, 1'b0, 1'b1, "R2");
    look(20'h12345, 1'b1, 20'hABCDE, "R3");
  endtask

  task automatic t_flush();
    flush();
    look(20'h12345, 1'b0, '0, "R6");
    look(20'h00042, 1'b0, '0, "R6");
  endtask

  task automatic t_order();
    for (int i = 0; i < 8; i++) fill(20'h100 + 20'(i), 20'h200 + 20'(i), 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) look(20'h100 + 20'(i), 1'b1, 20'h200 + 20'(i), "R4");
    fill(20'h300, 20'h400, 1'b0, 1'b0);
    look(20'h100, 1'b0, '0, "R4");
    look(20'h300, 1'b1, 20'h400, "R4");
    look(20'h101, 1'b1, 20'h201, "R4");
    fill(20'h301, 20'h401, 1'b0, 1'b0);
    look(20'h101, 1'b0, '0, "R4");
    inval(20'h103);
    look(20'h103, 1'b0, '0, "R7");
    look(20'h102, 1'b1, 20'h202, "R7");
    look(20'h104, 1'b1, 20'h204, "R7");
    fill(20'h302, 20'h402, 1'b0, 1'b0);
    look(20'h102, 1'b1, 20'h202, "R4");
    fill(20'h303, 20'h403, 1'b0, 1'b0);
    look(20'h102, 1'b0, '0, "R4");
    look(20'h302, 1'b1, 20'h402, "R4");
    look(20'h303, 1'b1, 20'h403, "R4");
  endtask

  task automatic t_overwrite();
    fill(20'h105, 20'hFFFFF, 1'b1, 1'b1);
    look(20'h105, 1'b1, 20'hFFFFF, "R5");
    look_perm(20'h105, 1'b1, 1'b1, "R5");
    look(20'h300, 1'b1, 20'h400, "R5");
    look(20'h301, 1'b1, 20'h401, "R5");
    look(20'h104, 1'b1, 20'h204, "R5");
    look(20'h106, 1'b1, 20'h206, "R5");
    look(20'h107, 1'b1, 20'h207, "R5");
  endtask

  task automatic t_inval_absent();
    inval(20'h99999);
    look(20'h300, 1'b1, 20'h400, "R8");
    look(20'h301, 1'b1, 20'h401, "R8");
    look(20'h302, 1'b1, 20'h402, "R8");
    look(20'h303, 1'b1, 20'h403, "R8");
    look(20'h104, 1'b1, 20'h204, "R8");
    look(20'h105, 1'b1, 20'hFFFFF, "R8");
    look(20'h106, 1'b1, 20'h206, "R8");
    look(20'h107, 1'b1, 20'h207, "R8");
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    base_wr = 1'b1;
    fill_en = 1'b1; fill_vpn = 20'h555; fill_ppn = 20'h666; fill_user = 1'b0; fill_wr = 1'b0;
    look(20'h104, 1'b1, 20'h204, "R10");
    look(20'h555, 1'b0, '0, "R10");
    @(negedge clk);
    base_wr = 1'b0; fill_en = 1'b0;
    look(20'h555, 1'b1, 20'h666, "R9");
    look(20'h104, 1'b0, '0, "R9");
    @(negedge clk);
    inval_en = 1'b1; inval_vpn = 20'h555;
    fill_en = 1'b1; fill_vpn = 20'h555; fill_ppn = 20'h777;
    look(20'h555, 1'b1, 20'h666, "R10");
    @(negedge clk);
    inval_en = 1'b0; fill_en = 1'b0;
    look(20'h555, 1'b1, 20'h777, "R9");
    @(negedge clk);
    inval_en = 1'b1; inval_vpn = 20'h555;
    fill_en = 1'b1; fill_vpn = 20'h556; fill_ppn = 20'h888;
    @(negedge clk);
    inval_en = 1'b0; fill_en = 1'b0;
    look(20'h555, 1'b0, '0, "R9");
    look(20'h556, 1'b1, 20'h888, "R9");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    lookup_vpn = '0; fill_en = 1'b0; fill_vpn = '0; fill_ppn = '0;
    fill_user = 1'b0; fill_wr = 1'b0; base_wr = 1'b0; inval_en = 1'b0; inval_vpn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_flush();
    t_order();
    t_overwrite();
    t_inval_absent();
    t_same_cycle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule